// File: doc/BRIEF.md
# Descriptor Ring Queue Engine

This block is the queue engine for one endpoint. It walks a linked ring of 16-byte descriptors that are held in memory. Software gives it a start address and a start strobe. The engine then reads each descriptor as four 32-bit words and decides whether the descriptor belongs to the hardware. When checking is enabled, it also checks the descriptor's byte checksum. For each descriptor it owns, it hands a buffer address and a length to an external data mover. When the mover finishes, the engine writes the descriptor back with its ownership bit cleared and, on receive, with the received length. It then follows the descriptor's next pointer.

A descriptor that the hardware does not own parks the engine. A descriptor that fails its checksum also parks it, and raises a checksum interrupt. A parked engine waits until software pulses resume, which re-reads the same descriptor, or start, which loads a new pointer. Descriptor traffic uses a word-wide request/response port. A request is held until it is acknowledged, and read data is valid in the acknowledge cycle.

Top module: `qe_ring_engine`

## Requirements
- R1: While reset is applied and after it is released, with no start pulse: memReq, memWe, xferValid, iocIrq, csumIrq and parked are 0 and curPtr is 0.
- R2: A start pulse, accepted when the engine is idle or parked, loads curPtr from startAddr. The engine then reads the descriptor words at curPtr+0, +4, +8 and +12 in that order. Bytes are little-endian: word 0 is flags [7:0], checksum [15:8] and capacity [31:16]; word 1 is the next pointer; word 2 is the buffer address; word 3 is length [15:0], extension length [23:16] and extension flags [31:24].
- R3: A descriptor with flag bit 0 (hardware-owned) clear causes no transfer and no write. The engine parks with curPtr unchanged. A resume pulse while parked fetches the same descriptor again.
- R4: When csumEn is 1, a descriptor whose 16 bytes do not sum to 0xFF (mod 256) gives a one-cycle csumIrq pulse. It causes no transfer and no write, and the engine parks with curPtr unchanged. When csumEn is 0, the checksum is ignored.
- R5: An owned descriptor with flag bit 2 (bypass) set causes no transfer and no write. curPtr moves on to its next pointer.
- R6: In transmit mode (txMode=1), xferAddr is word 2, xferLen is word 3 bits [15:0], and xferZlp is word 3 bit 29 (extension flag bit 5).
- R7: In receive mode, xferLen is word 0 bits [31:16] and xferZlp is 0. After xferDone, word 3 is written back with bits [15:0] replaced by xferRxLen and bits [31:16] unchanged.
- R8: Completion writes word 0 back with only bit 0 cleared. In receive mode the word 3 write comes first. curPtr then takes the next pointer.
- R9: iocIrq pulses for exactly one cycle after a completion, and only when flag bit 7 of that descriptor is set.
- R10: Flag bit 1 has no effect on processing and is written back unchanged.
- R11: Consecutive owned descriptors are processed around the ring without software action. The engine stops at the first descriptor it does not own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load startAddr and begin fetching |
| startAddr | input | ADDR_W | First descriptor address |
| resume | input | 1 | Re-fetch the current descriptor while parked |
| csumEn | input | 1 | Enable descriptor checksum validation |
| txMode | input | 1 | 1 = transmit endpoint, 0 = receive endpoint |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Word address of the request |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request accepted; read data valid |
| memRdata | input | 32 | Read data |
| xferValid | output | 1 | Buffer transfer requested |
| xferAddr | output | ADDR_W | Buffer address |
| xferLen | output | 16 | Bytes to send, or receive capacity |
| xferZlp | output | 1 | Append a zero-length packet (transmit) |
| xferDone | input | 1 | Transfer finished |
| xferRxLen | input | 16 | Bytes received, valid with xferDone |
| iocIrq | output | 1 | Completion interrupt pulse |
| csumIrq | output | 1 | Checksum failure interrupt pulse |
| parked | output | 1 | Engine waiting for resume or start |
| curPtr | output | ADDR_W | Current descriptor address |

## Verification
The bench builds the engine with ADDR_W=32. It uses a 64-word memory window, so descriptors at 0x40, 0x80 and 0xC0 can form a real three-entry ring that closes back on itself. With full-width addresses the next-pointer path and the write-offset checks see the same values software would program. Driving txMode and csumEn per case brings the transmit and receive write-back orders within reach, along with checksum-enforced and checksum-ignored runs.

// File: rtl/qe_pkg.sv
package qe_pkg;
  localparam int NUM_WORDS = 4;
  localparam int LAST_WORD = NUM_WORDS - 1;
  localparam int HWO_BIT = 0;
  localparam int BPS_BIT = 2;
  localparam int IOC_BIT = 7;
  localparam int ZLP_BIT = 29;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_XFER, S_WB3, S_WB0, S_PARK
  } qeState_t;

  typedef struct packed {
    logic       loadStart;
    logic       capWord;
    logic       capRx;
    logic       advance;
    logic [1:0] wordIdx;
  } qeStrobes_t;
endpackage

// File: rtl/qe_datapath.sv
module qe_datapath
  import qe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  qeStrobes_t        strb,
  input  logic              txMode,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [31:0]       memRdata,
  input  logic [LEN_W-1:0]  xferRxLen,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [ADDR_W-1:0] curPtr,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [LEN_W-1:0]  xferLen,
  output logic              xferZlp,
  output logic              descHwo,
  output logic              descBps,
  output logic              descIoc,
  output logic              csumOk
);
  logic [NUM_WORDS-1:0][31:0] descWord;
  logic [7:0]                 sumAcc;
  logic [LEN_W-1:0]           rxLenQ;

  function automatic logic [7:0] byteSum(input logic [31:0] w);
    return w[7:0] + w[15:8] + w[23:16] + w[31:24];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPtr   <= '0;
      descWord <= '0;
      sumAcc   <= '0;
      rxLenQ   <= '0;
    end else begin
      if (strb.loadStart)    curPtr <= startAddr;
      else if (strb.advance) curPtr <= descWord[1][ADDR_W-1:0];
      if (strb.capWord) begin
        descWord[strb.wordIdx] <= memRdata;
        sumAcc <= ((strb.wordIdx == 2'd0) ? 8'd0 : sumAcc) + byteSum(memRdata);
      end
      if (strb.capRx) rxLenQ <= xferRxLen;
    end
  end

  assign memAddr  = curPtr + ADDR_W'({strb.wordIdx, 2'b00});
  assign memWdata = (strb.wordIdx == 2'(LAST_WORD))
                  ? {descWord[3][31:LEN_W], rxLenQ}
                  : {descWord[0][31:1], 1'b0};

  assign xferAddr = descWord[2][ADDR_W-1:0];
  assign xferLen  = txMode ? descWord[3][LEN_W-1:0] : descWord[0][31:16];
  assign xferZlp  = txMode & descWord[3][ZLP_BIT];
  assign descHwo  = descWord[0][HWO_BIT];
  assign descBps  = descWord[0][BPS_BIT];
  assign descIoc  = descWord[0][IOC_BIT];
  assign csumOk   = (sumAcc == 8'hFF);
endmodule

// File: rtl/qe_ctrl.sv
module qe_ctrl
  import qe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       resume,
  input  logic       csumEn,
  input  logic       txMode,
  input  logic       memAck,
  input  logic       xferDone,
  input  logic       descHwo,
  input  logic       descBps,
  input  logic       descIoc,
  input  logic       csumOk,
  output qeStrobes_t strb,
  output logic       memReq,
  output logic       memWe,
  output logic       xferValid,
  output logic       iocIrq,
  output logic       csumIrq,
  output logic       parked
);
  qeState_t   state, stateNxt;
  logic [1:0] wordCnt, wordCntNxt;
  logic       iocNxt, csumNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wordCnt <= '0;
      iocIrq  <= 1'b0;
      csumIrq <= 1'b0;
    end else begin
      state   <= stateNxt;
      wordCnt <= wordCntNxt;
      iocIrq  <= iocNxt;
      csumIrq <= csumNxt;
    end
  end

  always_comb begin
    stateNxt     = state;
    wordCntNxt   = wordCnt;
    strb         = '0;
    strb.wordIdx = wordCnt;
    memReq       = 1'b0;
    memWe        = 1'b0;
    xferValid    = 1'b0;
    iocNxt       = 1'b0;
    csumNxt      = 1'b0;
    case (state)
      S_IDLE, S_PARK: begin
        if (start) begin
          strb.loadStart = 1'b1;
          stateNxt       = S_FETCH;
          wordCntNxt     = '0;
        end else if (resume && state == S_PARK) begin
          stateNxt   = S_FETCH;
          wordCntNxt = '0;
        end
      end
      S_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.capWord = 1'b1;
          if (wordCnt == 2'(LAST_WORD)) stateNxt = S_CHECK;
          else wordCntNxt = wordCnt + 2'd1;
        end
      end
      S_CHECK: begin
        if (!descHwo) stateNxt = S_PARK;
        else if (csumEn && !csumOk) begin
          csumNxt  = 1'b1;
          stateNxt = S_PARK;
        end else if (descBps) begin
          strb.advance = 1'b1;
          stateNxt     = S_FETCH;
          wordCntNxt   = '0;
        end else stateNxt = S_XFER;
      end
      S_XFER: begin
        xferValid = 1'b1;
        if (xferDone) begin
          strb.capRx = 1'b1;
          stateNxt   = txMode ? S_WB0 : S_WB3;
        end
      end
      S_WB3: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        strb.wordIdx = 2'(LAST_WORD);
        if (memAck) stateNxt = S_WB0;
      end
      S_WB0: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        strb.wordIdx = 2'd0;
        if (memAck) begin
          iocNxt       = descIoc;
          strb.advance = 1'b1;
          stateNxt     = S_FETCH;
          wordCntNxt   = '0;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign parked = (state == S_PARK);

  assert_ioc_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    iocIrq |=> !iocIrq);
  assert_csum_parks_R4: assert property (@(posedge clk) disable iff (!rstN)
    csumIrq |-> (state == S_PARK));
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(strb.wordIdx)));
endmodule

// File: rtl/qe_ring_engine.sv
module qe_ring_engine
  import qe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              resume,
  input  logic              csumEn,
  input  logic              txMode,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              xferValid,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [LEN_W-1:0]  xferLen,
  output logic              xferZlp,
  input  logic              xferDone,
  input  logic [LEN_W-1:0]  xferRxLen,
  output logic              iocIrq,
  output logic              csumIrq,
  output logic              parked,
  output logic [ADDR_W-1:0] curPtr
);
  qeStrobes_t strb;
  logic descHwo, descBps, descIoc, csumOk;

  qe_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .resume(resume), .csumEn(csumEn),
    .txMode(txMode), .memAck(memAck), .xferDone(xferDone), .descHwo(descHwo),
    .descBps(descBps), .descIoc(descIoc), .csumOk(csumOk), .strb(strb),
    .memReq(memReq), .memWe(memWe), .xferValid(xferValid), .iocIrq(iocIrq),
    .csumIrq(csumIrq), .parked(parked)
  );

  qe_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .txMode(txMode), .startAddr(startAddr),
    .memRdata(memRdata), .xferRxLen(xferRxLen), .memAddr(memAddr),
    .memWdata(memWdata), .curPtr(curPtr), .xferAddr(xferAddr), .xferLen(xferLen),
    .xferZlp(xferZlp), .descHwo(descHwo), .descBps(descBps), .descIoc(descIoc),
    .csumOk(csumOk)
  );

  assert_xfer_owned_R5: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> (descHwo && !descBps && !memReq));
  assert_wr_offsets_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> ((memAddr - curPtr) == ADDR_W'(0) ||
                           (memAddr - curPtr) == ADDR_W'(12)));
  assert_rx_len_wb_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && (memAddr - curPtr) == ADDR_W'(12)) |-> !txMode);
endmodule

// File: tb/tb_qe_ring_engine.sv
module tb_qe_ring_engine;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, start, resume, csumEn, txMode, memReq, memWe, memAck;
  logic [31:0] startAddr, memAddr, memWdata, memRdata, xferAddr, curPtr;
  logic xferValid, xferZlp, xferDone, iocIrq, csumIrq, parked;
  logic [15:0] xferLen, xferRxLen;

  qe_ring_engine #(.ADDR_W(ADDR_W)) dut (.*);

  logic [31:0] mem [0:63];
  assign memAck   = memReq;
  assign memRdata = mem[memAddr[7:2]];

  int rdCnt = 0, wrCnt = 0, xferCnt = 0, iocCnt = 0, csCnt = 0, dly = 0;
  logic [31:0] rdLog [0:7];
  logic [31:0] wrLog [0:7];
  logic [31:0] lastAddr;
  logic [15:0] lastLen;
  logic        lastZlp;

  always @(posedge clk) begin
    if (memReq && memWe) begin
      mem[memAddr[7:2]] <= memWdata;
      wrLog[wrCnt % 8] <= memAddr;
      wrCnt <= wrCnt + 1;
    end else if (memReq) begin
      rdLog[rdCnt % 8] <= memAddr;
      rdCnt <= rdCnt + 1;
    end
    if (xferDone) xferDone <= 1'b0;
    else if (xferValid) begin
      if (dly == 2) begin
        xferDone <= 1'b1;
        dly <= 0;
        lastAddr <= xferAddr;
        lastLen  <= xferLen;
        lastZlp  <= xferZlp;
        xferCnt  <= xferCnt + 1;
      end else dly <= dly + 1;
    end
  end

  always @(negedge clk) begin
    if (iocIrq)  iocCnt <= iocCnt + 1;
    if (csumIrq) csCnt  <= csCnt + 1;
  end

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic placeDesc(input logic [31:0] at, input logic [7:0] flag,
                           input logic [7:0] ext, input logic [15:0] bufLen,
                           input logic [15:0] cap, input logic [31:0] nxt,
                           input logic [31:0] buff, input logic bad);
    logic [31:0] w0, w3;
    logic [7:0] s;
    w0 = {cap, 8'h00, flag};
    w3 = {ext, 8'h5A, bufLen};
    s = 8'd0;
    for (int b = 0; b < 4; b++)
      s = s + w0[8*b +: 8] + nxt[8*b +: 8] + buff[8*b +: 8] + w3[8*b +: 8];
    s = 8'hFF - s;
    if (bad) s = s ^ 8'h01;
    w0[15:8] = s;
    mem[at[7:2]]     = w0;
    mem[at[7:2] + 1] = nxt;
    mem[at[7:2] + 2] = buff;
    mem[at[7:2] + 3] = w3;
  endtask

  task automatic waitPark();
    for (int k = 0; k < 400 && !parked; k++) @(negedge clk);
    chk("parked", {31'd0, parked}, 32'd1);
    @(negedge clk);
  endtask

  task automatic pulseStart(input logic [31:0] a);
    @(negedge clk);
    startAddr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  typedef struct packed {
    logic txm; logic [7:0] flag; logic [7:0] ext; logic [15:0] bufLen;
    logic [15:0] cap; logic bad; logic [15:0] rxLen;
    logic expXfer; logic [15:0] expLen; logic expZlp; logic expIoc; logic expCs;
    logic [7:0] expFlag; logic [15:0] expBl; logic [1:0] expWr; logic [31:0] expPtr;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b1, 8'h81, 8'h00, 16'h0123, 16'h0200, 1'b0, 16'h0000, 1'b1, 16'h0123, 1'b0, 1'b1, 1'b0, 8'h80, 16'h0123, 2'd1, 32'h80},
    '{1'b1, 8'h01, 8'h20, 16'h0040, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0040, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0040, 2'd1, 32'h80},
    '{1'b0, 8'h81, 8'h00, 16'h0000, 16'h0400, 1'b0, 16'h0155, 1'b1, 16'h0400, 1'b0, 1'b1, 1'b0, 8'h80, 16'h0155, 2'd2, 32'h80},
    '{1'b0, 8'h01, 8'h20, 16'h0000, 16'h0010, 1'b0, 16'h0008, 1'b1, 16'h0010, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0008, 2'd2, 32'h80},
    '{1'b1, 8'h80, 8'h00, 16'h0011, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h80, 16'h0011, 2'd0, 32'h40},
    '{1'b1, 8'h85, 8'h00, 16'h0022, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h85, 16'h0022, 2'd0, 32'h80},
    '{1'b1, 8'h81, 8'h00, 16'h0033, 16'h0000, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 8'h81, 16'h0033, 2'd0, 32'h40},
    '{1'b1, 8'h83, 8'h00, 16'h0007, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0007, 1'b0, 1'b1, 1'b0, 8'h82, 16'h0007, 2'd1, 32'h80}
  };

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int x0, i0, c0, w0, r0;
    for (int k = 0; k < 64; k++) mem[k] = 32'd0;
    rstN = 1'b0; start = 1'b0; resume = 1'b0; csumEn = 1'b1; txMode = 1'b1;
    startAddr = 32'd0; xferDone = 1'b0; xferRxLen = 16'd0;
    repeat (3) @(negedge clk);
    chk("R1 memReq in reset", {31'd0, memReq}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 memReq", {31'd0, memReq}, 32'd0);
    chk("R1 xferValid", {31'd0, xferValid}, 32'd0);
    chk("R1 irqs", {30'd0, iocIrq, csumIrq}, 32'd0);
    chk("R1 parked", {31'd0, parked}, 32'd0);
    chk("R1 curPtr", curPtr, 32'd0);

    // vector table: R3 R4 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < 8; v++) begin
      vec_t t = VECS[v];
      txMode = t.txm;
      xferRxLen = t.rxLen;
      mem[32] = 32'd0;
      placeDesc(32'h40, t.flag, t.ext, t.bufLen, t.cap, 32'h80, 32'h1000 + 32'(v) * 16, t.bad);
      x0 = xferCnt; i0 = iocCnt; c0 = csCnt; w0 = wrCnt; r0 = rdCnt;
      pulseStart(32'h40);
      waitPark();
      for (int k = 0; k < 4; k++)
        chk($sformatf("R2 read order v%0d", v), rdLog[(r0 + k) % 8], 32'h40 + 32'(4 * k));
      chk($sformatf("R3/R5 xfer count v%0d", v), 32'(xferCnt - x0), {31'd0, t.expXfer});
      if (t.expXfer) begin
        chk($sformatf("R6 addr v%0d", v), lastAddr, 32'h1000 + 32'(v) * 16);
        chk($sformatf("R6/R7 len v%0d", v), {16'd0, lastLen}, {16'd0, t.expLen});
        chk($sformatf("R6 zlp v%0d", v), {31'd0, lastZlp}, {31'd0, t.expZlp});
      end
      chk($sformatf("R9 ioc v%0d", v), 32'(iocCnt - i0), {31'd0, t.expIoc});
      chk($sformatf("R4 csum irq v%0d", v), 32'(csCnt - c0), {31'd0, t.expCs});
      chk($sformatf("R8/R10 flag v%0d", v), {24'd0, mem[16][7:0]}, {24'd0, t.expFlag});
      chk($sformatf("R7 len field v%0d", v), {16'd0, mem[19][15:0]}, {16'd0, t.expBl});
      chk($sformatf("R7 upper kept v%0d", v), {16'd0, mem[19][31:16]}, {16'd0, t.ext, 8'h5A});
      chk($sformatf("R8 write count v%0d", v), 32'(wrCnt - w0), {30'd0, t.expWr});
      if (t.expWr == 2'd2) begin
        chk($sformatf("R8 rx wb first v%0d", v), wrLog[w0 % 8], 32'h4C);
        chk($sformatf("R8 rx wb second v%0d", v), wrLog[(w0 + 1) % 8], 32'h40);
      end else if (t.expWr == 2'd1)
        chk($sformatf("R8 tx wb v%0d", v), wrLog[w0 % 8], 32'h40);
      chk($sformatf("R3/R8 curPtr v%0d", v), curPtr, t.expPtr);
    end

    // R3: resume re-fetches the same descriptor once it is owned
    txMode = 1'b1;
    mem[32] = 32'd0;
    placeDesc(32'h40, 8'h80, 8'h00, 16'h0009, 16'h0, 32'h80, 32'h2000, 1'b0);
    pulseStart(32'h40);
    waitPark();
    chk("R3 parked at same ptr", curPtr, 32'h40);
    placeDesc(32'h40, 8'h81, 8'h00, 16'h0009, 16'h0, 32'h80, 32'h2000, 1'b0);
    x0 = xferCnt;
    @(negedge clk); resume = 1'b1; @(negedge clk); resume = 1'b0;
    waitPark();
    chk("R3 resume transfers", 32'(xferCnt - x0), 32'd1);
    chk("R3 resume len", {16'd0, lastLen}, 32'h9);
    chk("R3 resume ptr", curPtr, 32'h80);

    // R4: bad checksum ignored when checking is off
    csumEn = 1'b0;
    mem[32] = 32'd0;
    placeDesc(32'h40, 8'h01, 8'h00, 16'h0015, 16'h0, 32'h80, 32'h3000, 1'b1);
    x0 = xferCnt; c0 = csCnt;
    pulseStart(32'h40);
    waitPark();
    chk("R4 csum off transfers", 32'(xferCnt - x0), 32'd1);
    chk("R4 csum off no irq", 32'(csCnt - c0), 32'd0);
    csumEn = 1'b1;

    // R11: three-entry ring closes on itself
    placeDesc(32'h40, 8'h81, 8'h00, 16'h0001, 16'h0, 32'h80, 32'h4000, 1'b0);
    placeDesc(32'h80, 8'h81, 8'h00, 16'h0002, 16'h0, 32'hC0, 32'h4100, 1'b0);
    placeDesc(32'hC0, 8'h81, 8'h00, 16'h0003, 16'h0, 32'h40, 32'h4200, 1'b0);
    x0 = xferCnt; i0 = iocCnt;
    pulseStart(32'h40);
    waitPark();
    chk("R11 ring transfers", 32'(xferCnt - x0), 32'd3);
    chk("R11 ring iocs", 32'(iocCnt - i0), 32'd3);
    chk("R11 last len", {16'd0, lastLen}, 32'h3);
    chk("R11 stops at first", curPtr, 32'h40);
    chk("R11 flags cleared", {8'd0, mem[16][7:0], mem[32][7:0], mem[48][7:0]}, 32'h00808080);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule